// File: doc/BRIEF.md
# Line-Buffered Field Memory Write Port

This block is the write side of a field memory that is organised as lines. Pixel words arrive one per write clock and are gathered in a write register that holds one line. A line number, shifted in one bit at a time, selects the line of the shared array that receives the gathered words. The words reach the array only when the writer issues a one-clock transfer cycle. At that point the block drives a write-line interface for one cycle: a valid strobe, the line index, and the whole line register as a flat vector. The array owner and the read port sit beyond that interface.

The word pointer moves forward while write enable is high. The input enable works as a mask: when it is low, the pointer still moves but the word is not stored, so the skipped positions keep their old contents. An address-enable input shifts in the line number, most significant bit first. The reset/transfer input starts a single-clock reset cycle. Every reset cycle commits the line register. When the line-increment and address-enable inputs are also high, the reset cycle steps to the next line. The default array is 290 lines of 768 words of 12 bits, and all of these sizes are parameters.

Top module: `field_line_wr`

## Requirements
- R1: After reset, the write-line valid output is low, the line address is 0, the word pointer is 0 and every word of the line register is zero.
- R2: On a rising clock edge with write enable high, input enable high and reset/transfer low, the input word is stored at the pointer position (bits [12*i+11:12*i] of the line data for word i) and the pointer advances by one.
- R3: On a rising clock edge with write enable high, input enable low and reset/transfer low, the pointer advances by one and the line register is unchanged, so skipped words keep their previous contents.
- R4: On a rising clock edge with write enable low and reset/transfer low, the pointer holds and no word is stored.
- R5: On an edge where address enable is high and reset/transfer is low, the serial address bit is shifted in, most significant bit first. On the edge after the ninth bit, the shifted value becomes the line address and the pointer returns to 0. That loading edge takes precedence over a same-cycle increment and over pointer advance, but a write on that edge is still stored at the old pointer.
- R6: A reset cycle (reset/transfer high) that has line increment and address enable both high raises the line address by one and returns the pointer to 0. No reset cycle stores a word or advances the pointer.
- R7: Every reset cycle raises the write-line valid output for exactly the following clock cycle. In that cycle the index equals the line address held before the reset edge, and the data equals the line register.
- R8: A reset cycle whose line address is 290 or more (at least the line count) produces no valid strobe, so the array is left unchanged.
- R9: The pointer saturates at word 767. Further writes overwrite that last word.
- R10: A reset cycle discards a partly shifted serial address. The next address load needs nine fresh bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge active |
| rstN | input | 1 | Active-low reset |
| wrEn | input | 1 | Write enable: pointer advance and data capture |
| inEn | input | 1 | Input enable; low masks the store |
| dataIn | input | 12 | Input pixel word |
| addrEn | input | 1 | Address enable: serial shift, and qualifies increment |
| resetXfer | input | 1 | Reset/transfer cycle request |
| lineInc | input | 1 | Line increment request within a reset cycle |
| addrSerial | input | 1 | Serial line address bit |
| lineWrValid | output | 1 | One-cycle strobe to write a line into the array |
| lineWrIdx | output | 9 | Array line being written |
| lineWrData | output | 9216 | Whole line register, word i at bits [12*i+11:12*i] |

## Verification
The main collision is between a pixel write and the loading of a freshly shifted line address, because both act on the same edge. Address shifting runs alongside writing, so the bench deliberately issues a write on the edge after the ninth address bit. It then judges the following transfer: the word must sit at the old pointer position, and the next write must land at word 0 of the new line. Random traffic also places reset cycles at random points inside address loads and inside masked write runs. Each transfer is compared word by word against a reference line register kept in the bench.

// File: rtl/fmw_pkg.sv
package fmw_pkg;

  // Strobes the control sends to the datapath each cycle
  typedef struct packed {
    logic storeWord;  // write dataIn at the current pointer
    logic xferLine;   // reset cycle: commit the line register
    logic addrLoad;   // serial address is being loaded this edge
  } wrStrobe_t;

endpackage

// File: rtl/field_line_wr_ctrl.sv
module field_line_wr_ctrl
  import fmw_pkg::*;
#(
  parameter int WORDS     = 768,
  parameter int ADDR_BITS = 9
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic                         inEn,
  input  logic                         addrEn,
  input  logic                         resetXfer,
  input  logic                         lineInc,
  input  logic                         addrSerial,
  output wrStrobe_t                    strobes,
  output logic [$clog2(WORDS)-1:0]     wordPtr,
  output logic [ADDR_BITS-1:0]         lineAddr
);

  localparam int PTR_W = $clog2(WORDS);
  localparam int CNT_W = $clog2(ADDR_BITS);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(WORDS - 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(ADDR_BITS - 1);

  logic [ADDR_BITS-1:0] shiftReg;
  logic [CNT_W-1:0]     bitCnt;
  logic                 loadPending;
  logic                 setCycle;
  logic                 incCycle;
  logic                 advance;

  always_comb begin
    setCycle = addrEn && !resetXfer;
    incCycle = resetXfer && lineInc && addrEn;
    advance  = wrEn && !resetXfer;
  end

  // Serial address capture, MSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '0;
      bitCnt      <= '0;
      loadPending <= 1'b0;
    end else if (setCycle) begin
      shiftReg <= {shiftReg[ADDR_BITS-2:0], addrSerial};
      if (bitCnt == LAST_BIT) begin
        bitCnt      <= '0;
        loadPending <= 1'b1;
      end else begin
        bitCnt      <= bitCnt + 1'b1;
        loadPending <= 1'b0;
      end
    end else begin
      loadPending <= 1'b0;
      if (resetXfer) bitCnt <= '0;
    end
  end

  // Line address: load has priority over increment
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            lineAddr <= '0;
    else if (loadPending) lineAddr <= shiftReg;
    else if (incCycle)    lineAddr <= lineAddr + 1'b1;
  end

  // Word pointer with saturation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           wordPtr <= '0;
    else if (loadPending || incCycle)    wordPtr <= '0;
    else if (advance && wordPtr != LAST_PTR) wordPtr <= wordPtr + 1'b1;
  end

  always_comb begin
    strobes.storeWord = advance && inEn;
    strobes.xferLine  = resetXfer;
    strobes.addrLoad  = loadPending;
  end

endmodule

// File: rtl/field_line_wr_dp.sv
module field_line_wr_dp
  import fmw_pkg::*;
#(
  parameter int WORDS     = 768,
  parameter int LINES     = 290,
  parameter int DATA_W    = 12,
  parameter int ADDR_BITS = 9
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  wrStrobe_t                    strobes,
  input  logic [$clog2(WORDS)-1:0]     wordPtr,
  input  logic [ADDR_BITS-1:0]         lineAddr,
  input  logic [DATA_W-1:0]            dataIn,
  output logic                         lineWrValid,
  output logic [ADDR_BITS-1:0]         lineWrIdx,
  output logic [WORDS*DATA_W-1:0]      lineWrData
);

  localparam int PTR_W = $clog2(WORDS);
  localparam logic [ADDR_BITS:0] LINE_LIMIT = (ADDR_BITS + 1)'(LINES);

  logic [DATA_W-1:0] lineReg [WORDS];
  logic              lineInRange;

  // One register per word, each with its own write decode
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        lineReg[g] <= '0;
      else if (strobes.storeWord && wordPtr == PTR_W'(g))
        lineReg[g] <= dataIn;
    end
    assign lineWrData[g*DATA_W +: DATA_W] = lineReg[g];
  end

  assign lineInRange = {1'b0, lineAddr} < LINE_LIMIT;

  // Line register is stable across a reset cycle, so the flat view is
  // the committed data while the strobe is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineWrValid <= 1'b0;
      lineWrIdx   <= '0;
    end else begin
      lineWrValid <= strobes.xferLine && lineInRange;
      if (strobes.xferLine) lineWrIdx <= lineAddr;
    end
  end

endmodule

// File: rtl/field_line_wr.sv
module field_line_wr
  import fmw_pkg::*;
#(
  parameter int WORDS     = 768,
  parameter int LINES     = 290,
  parameter int DATA_W    = 12,
  parameter int ADDR_BITS = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic                     inEn,
  input  logic [DATA_W-1:0]        dataIn,
  input  logic                     addrEn,
  input  logic                     resetXfer,
  input  logic                     lineInc,
  input  logic                     addrSerial,
  output logic                     lineWrValid,
  output logic [ADDR_BITS-1:0]     lineWrIdx,
  output logic [WORDS*DATA_W-1:0]  lineWrData
);

  localparam int PTR_W = $clog2(WORDS);

  wrStrobe_t            strobes;
  logic [PTR_W-1:0]     wordPtr;
  logic [ADDR_BITS-1:0] lineAddr;

  field_line_wr_ctrl #(
    .WORDS(WORDS), .ADDR_BITS(ADDR_BITS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .inEn(inEn), .addrEn(addrEn),
    .resetXfer(resetXfer), .lineInc(lineInc), .addrSerial(addrSerial),
    .strobes(strobes), .wordPtr(wordPtr), .lineAddr(lineAddr)
  );

  field_line_wr_dp #(
    .WORDS(WORDS), .LINES(LINES), .DATA_W(DATA_W), .ADDR_BITS(ADDR_BITS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wordPtr(wordPtr),
    .lineAddr(lineAddr), .dataIn(dataIn), .lineWrValid(lineWrValid),
    .lineWrIdx(lineWrIdx), .lineWrData(lineWrData)
  );

endmodule

// File: rtl/field_line_wr_chk.sv
module field_line_wr_chk
  import fmw_pkg::*;
#(
  parameter int WORDS     = 768,
  parameter int LINES     = 290,
  parameter int DATA_W    = 12,
  parameter int ADDR_BITS = 9
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     wrEn,
  input logic                     inEn,
  input logic                     addrEn,
  input logic                     resetXfer,
  input logic                     lineInc,
  input wrStrobe_t                strobes,
  input logic [$clog2(WORDS)-1:0] wordPtr,
  input logic [ADDR_BITS-1:0]     lineAddr,
  input logic                     lineWrValid,
  input logic [ADDR_BITS-1:0]     lineWrIdx,
  input logic [WORDS*DATA_W-1:0]  lineWrData
);

  localparam int PTR_W = $clog2(WORDS);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(WORDS - 1);
  localparam logic [ADDR_BITS:0] LINE_LIMIT = (ADDR_BITS + 1)'(LINES);

  p_store_advance_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && inEn && !resetXfer && !strobes.addrLoad && wordPtr != LAST_PTR)
      |=> wordPtr == $past(wordPtr) + 1'b1);

  p_mask_keep_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !inEn && !resetXfer && !strobes.addrLoad && wordPtr != LAST_PTR)
      |=> (wordPtr == $past(wordPtr) + 1'b1) && $stable(lineWrData));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !resetXfer && !strobes.addrLoad)
      |=> $stable(wordPtr) && $stable(lineWrData));

  p_load_ptr_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.addrLoad |=> wordPtr == '0);

  p_line_inc_r6: assert property (@(posedge clk) disable iff (!rstN)
    (resetXfer && lineInc && addrEn && !strobes.addrLoad)
      |=> (lineAddr == $past(lineAddr) + 1'b1) && (wordPtr == '0));

  p_reset_no_store_r6: assert property (@(posedge clk) disable iff (!rstN)
    resetXfer |=> $stable(lineWrData));

  p_xfer_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    lineWrValid |-> $past(resetXfer) && (lineWrIdx == $past(lineAddr)));

  p_line_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    lineWrValid |-> ({1'b0, lineWrIdx} < LINE_LIMIT));

  p_ptr_sat_r9: assert property (@(posedge clk) disable iff (!rstN)
    wordPtr <= LAST_PTR);

endmodule

bind field_line_wr field_line_wr_chk #(
  .WORDS(WORDS), .LINES(LINES), .DATA_W(DATA_W), .ADDR_BITS(ADDR_BITS)
) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .inEn(inEn), .addrEn(addrEn),
  .resetXfer(resetXfer), .lineInc(lineInc), .strobes(strobes),
  .wordPtr(wordPtr), .lineAddr(lineAddr), .lineWrValid(lineWrValid),
  .lineWrIdx(lineWrIdx), .lineWrData(lineWrData)
);

// File: tb/field_line_wr_tb_top.sv
module field_line_wr_tb_top;

  localparam int WORDS = 768;
  localparam int LINES = 290;
  localparam int DW    = 12;
  localparam int AB    = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 0, inEn = 0, addrEn = 0, resetXfer = 0, lineInc = 0, addrSerial = 0;
  logic [DW-1:0] dataIn = '0;
  logic lineWrValid;
  logic [AB-1:0] lineWrIdx;
  logic [WORDS*DW-1:0] lineWrData;

  always #5 clk = ~clk;

  field_line_wr dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .inEn(inEn), .dataIn(dataIn),
    .addrEn(addrEn), .resetXfer(resetXfer), .lineInc(lineInc),
    .addrSerial(addrSerial), .lineWrValid(lineWrValid),
    .lineWrIdx(lineWrIdx), .lineWrData(lineWrData)
  );

  int checks = 0;
  int errors = 0;
  string curTag = "R7";

  // Reference model state
  logic [DW-1:0] mReg [WORDS];
  int mPtr = 0, mLine = 0, mCnt = 0;
  logic [AB-1:0] mShift = '0;
  bit mPending = 0;
  bit expValid = 0;
  int expIdx = 0;

  function automatic logic [WORDS*DW-1:0] packModel();
    logic [WORDS*DW-1:0] v;
    for (int i = 0; i < WORDS; i++) v[i*DW +: DW] = mReg[i];
    return v;
  endfunction

  task automatic check(input string tag, input bit ok, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Apply one cycle: drive at negedge, update model at posedge, check at next negedge
  task automatic step(input bit we, input bit ie, input logic [DW-1:0] d,
                      input bit ae, input bit rx, input bit inc, input bit bt);
    bit pend;
    wrEn = we; inEn = ie; dataIn = d; addrEn = ae; resetXfer = rx;
    lineInc = inc; addrSerial = bt;
    @(posedge clk);
    pend = mPending;
    expValid = rx && (mLine < LINES);
    if (rx) expIdx = mLine;
    if (!rx && we && ie) mReg[mPtr] = d;
    if (pend) mLine = int'(mShift);
    else if (rx && inc && ae) mLine = (mLine + 1) % (1 << AB);
    if (pend || (rx && inc && ae)) mPtr = 0;
    else if (!rx && we && mPtr != WORDS - 1) mPtr++;
    if (ae && !rx) begin
      mShift = {mShift[AB-2:0], bt};
      if (mCnt == AB - 1) begin mCnt = 0; mPending = 1; end
      else begin mCnt++; mPending = 0; end
    end else begin
      mPending = 0;
      if (rx) mCnt = 0;
    end
    @(negedge clk);
    check(curTag, lineWrValid == expValid, "valid", longint'(lineWrValid), longint'(expValid));
    if (expValid && lineWrValid) begin
      check(curTag, int'(lineWrIdx) == expIdx, "index", longint'(lineWrIdx), longint'(expIdx));
      for (int i = 0; i < WORDS; i++)
        if (lineWrData[i*DW +: DW] != mReg[i]) begin
          check(curTag, 1'b0, $sformatf("word %0d", i),
                longint'(lineWrData[i*DW +: DW]), longint'(mReg[i]));
          break;
        end
      checks++;
    end
  endtask

  task automatic idle(); step(0, 0, '0, 0, 0, 0, 0); endtask
  task automatic wr(input logic [DW-1:0] d); step(1, 1, d, 0, 0, 0, 0); endtask
  task automatic xfer(); step(0, 0, '0, 0, 1, 0, 0); endtask
  task automatic incLine(); step(0, 0, '0, 1, 1, 1, 0); endtask
  task automatic loadAddr(input int a);
    for (int i = AB - 1; i >= 0; i--) step(0, 0, '0, 1, 0, 0, a[i]);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < WORDS; i++) mReg[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", lineWrValid == 1'b0, "valid in reset", longint'(lineWrValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    curTag = "R1";
    xfer();                                   // line 0, all-zero data

    // R5: load line 5, with a write colliding with the loading edge
    curTag = "R5";
    wr(12'h111); wr(12'h222);                 // pointer now 2
    for (int i = AB - 1; i >= 0; i--) step(0, 0, '0, 1, 0, 0, AB'(5) >> i);
    step(1, 1, 12'hABC, 0, 0, 0, 0);          // loading edge: stored at word 2
    wr(12'h333);                              // lands at word 0
    xfer();

    // R2/R3/R4: stores, masked advance, idle hold
    curTag = "R2";
    loadAddr(7);
    wr(12'h001); wr(12'h002);
    xfer();
    curTag = "R3";
    step(1, 0, 12'hFFF, 0, 0, 0, 0);          // masked, pointer moves
    step(1, 0, 12'hEEE, 0, 0, 0, 0);
    wr(12'h004);
    xfer();
    curTag = "R4";
    step(0, 1, 12'h555, 0, 0, 0, 0);
    step(0, 0, 12'h666, 0, 0, 0, 0);
    wr(12'h005);
    xfer();

    // R9: saturation at the last word
    curTag = "R9";
    loadAddr(20);
    for (int i = 0; i < WORDS + 10; i++) wr(DW'(i * 7 + 3));
    xfer();

    // R6: increment, and R8 out-of-range line
    curTag = "R6";
    loadAddr(10);
    incLine();                                // commits line 10, moves to 11
    wr(12'h0A0);
    xfer();
    curTag = "R8";
    loadAddr(289);
    incLine();                                // commits 289, now 290
    xfer();                                   // no strobe
    loadAddr(300);
    xfer();                                   // no strobe

    // R10: partial address dropped by a reset cycle
    curTag = "R10";
    for (int i = 0; i < 4; i++) step(0, 0, '0, 1, 0, 0, 1);
    xfer();
    loadAddr(3);
    xfer();

    // Random mix, all checked against the model
    curTag = "R7";
    for (int n = 0; n < 6000; n++) begin
      bit rx, ae;
      rx = ($urandom % 24) == 0;
      ae = ($urandom % 3) == 0;
      step(($urandom % 4) != 0, ($urandom % 3) != 0, DW'($urandom),
           ae, rx, ($urandom % 2) == 1, ($urandom % 2) == 1);
    end
    xfer();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule